// File: doc/BRIEF.md
# FFT Byte-Serial I/O Sequencer

This block sits between a narrow bidirectional pin group and a four-point FFT core. Its job is to turn a stream of hand-strobed bytes into a parallel sample vector for the core, start the core, and hand the results back a byte at a time. Two mode switches act as strobes. A rising edge on the load switch takes one byte from the input bus. A rising edge on the read switch moves the output bus to the next result byte.

Each complex value uses two bytes, the real part first and the imaginary part second. A frame is therefore eight bytes in each direction. The controller changes the pin direction through the output-enable bits: the pins are inputs everywhere except in the output phase. A single seven-segment digit always shows the current phase. After the last result byte has been read, the controller returns to idle and accepts a new frame. The FFT arithmetic lives in the attached core and is not part of this block.

Top module: `fft_io_sequencer`

## Requirements
- R1: While reset (active low) is asserted and on its release, the digit shows the idle glyph. The output-enable bits, the output bus and the core start line are all zero.
- R2: Each switch passes through a two-flop synchroniser followed by an edge detector. Only a rising edge of switch bit 0 takes a byte from the input bus, so a switch held high for many cycles takes exactly one byte.
- R3: Load bytes are numbered 0 to 7 in arrival order. Byte 2k is the real part of sample k and byte 2k+1 is its imaginary part. On the core sample vector, the real part of sample k sits at bits [16k+7:16k] and the imaginary part at bits [16k+15:16k+8].
- R4: The core start line pulses for exactly one cycle, once per frame, and only after the eighth load byte. It never pulses after fewer bytes.
- R5: In the processing phase, rising edges on both strobe switches are ignored. The core result vector is captured in the cycle in which core done is high, and later changes on the result inputs do not affect the output.
- R6: All eight output-enable bits are 1 in the output phase and 0 in every other phase. The output bus is zero whenever the output-enable bits are zero.
- R7: In the output phase, the output bus carries result byte j, numbered and laid out as in R3. Byte 0 appears on entry to the phase, and each rising edge of switch bit 1 advances to the next byte.
- R8: After the eighth read edge, the controller returns to idle, and the next frame loads and transforms correctly.
- R9: The digit pattern is {g,f,e,d,c,b,a} with active-high segments by default. The glyphs are 0x3F for idle, 0x38 for load, 0x73 for processing (start and waiting) and 0x5C for output.
- R10: A read-switch edge in the idle or load phase is ignored. A load-switch edge in the output phase is ignored.
- R11: Switch bits other than 0 and 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sw | input | 8 | Switch bank; bit 0 is the load strobe and bit 1 the read strobe |
| bus_in | input | 8 | Byte from the bidirectional pins |
| bus_out | output | 8 | Byte driven to the bidirectional pins |
| bus_oe | output | 8 | Per-pin output enable |
| seg | output | 7 | Seven-segment pattern {g,f,e,d,c,b,a} |
| core_start | output | 1 | One-cycle start pulse to the FFT core |
| core_samples | output | 64 | Loaded time-domain samples, packed as in R3 |
| core_results | input | 64 | Frequency bins from the core, packed as in R3 |
| core_done | input | 1 | Core completion pulse |

## Verification
A byte index that has slipped shows up on the output bus within one frame: every later bin appears in the wrong byte position, or the start pulse arrives early or late relative to the eighth load strobe. A wrong phase shows up on the digit and the output-enable bits in the very cycle it happens, because both are decoded straight from the phase register. The sweeps use many sample frames, with each transform recomputed arithmetically. Stray strobes are injected in every phase, so a missed or doubled edge corrupts a visible bin within the same frame.

// File: rtl/fio_pkg.sv
package fio_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_KICK,
      ST_WAIT,
      ST_SHOW
   } fio_state_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_LOAD,
      PH_PROC,
      PH_SHOW
   } fio_phase_e;

   // segment order {g,f,e,d,c,b,a}, active high
   localparam logic [6:0] GLY_IDLE = 7'h3F;
   localparam logic [6:0] GLY_LOAD = 7'h38;
   localparam logic [6:0] GLY_PROC = 7'h73;
   localparam logic [6:0] GLY_SHOW = 7'h5C;

endpackage

// File: rtl/fio_edge_sync.sv
module fio_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic rise
);

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("fio_edge_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else        sync_q[i] <= level;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else        sync_q[i] <= sync_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[STAGES-1];
   end

   assign rise = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/fio_byte_bank.sv
module fio_byte_bank #(
   parameter int DATA_W  = 8,
   parameter int N_BYTES = 8,
   localparam int IDX_W  = (N_BYTES > 1) ? $clog2(N_BYTES) : 1,
   localparam int VEC_W  = N_BYTES * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic              bulk_en,
   input  logic [VEC_W-1:0]  bulk_vec,
   output logic [VEC_W-1:0]  vec
);

   if (DATA_W < 1 || N_BYTES < 1) begin : g_bad_geom
      $error("fio_byte_bank: DATA_W and N_BYTES must be positive");
   end

   for (genvar i = 0; i < N_BYTES; i++) begin : g_slot
      logic [DATA_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q <= '0;
         end else if (bulk_en) begin
            slot_q <= bulk_vec[i*DATA_W +: DATA_W];
         end else if (wr_en && (wr_idx == IDX_W'(i))) begin
            slot_q <= wr_byte;
         end
      end
      assign vec[i*DATA_W +: DATA_W] = slot_q;
   end

endmodule

// File: rtl/fio_glyph_drv.sv
module fio_glyph_drv
   import fio_pkg::*;
#(
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  fio_phase_e  phase,
   output logic [6:0]  seg
);

   logic [6:0] raw;

   always_comb begin
      unique case (phase)
         PH_IDLE: raw = GLY_IDLE;
         PH_LOAD: raw = GLY_LOAD;
         PH_PROC: raw = GLY_PROC;
         PH_SHOW: raw = GLY_SHOW;
         default: raw = GLY_IDLE;
      endcase
   end

   if (ACTIVE_LOW) begin : g_low
      assign seg = ~raw;
   end else begin : g_high
      assign seg = raw;
   end

endmodule

// File: rtl/fft_io_sequencer.sv
module fft_io_sequencer
   import fio_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int N_PTS          = 4,
   parameter int SW_W           = 8,
   parameter int LOAD_SW        = 0,
   parameter int READ_SW        = 1,
   parameter int SYNC_STAGES    = 2,
   parameter bit SEG_ACTIVE_LOW = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [SW_W-1:0]           mode_sw,
   input  logic [DATA_W-1:0]         bus_in,
   output logic [DATA_W-1:0]         bus_out,
   output logic [DATA_W-1:0]         bus_oe,
   output logic [6:0]                seg,
   output logic                      core_start,
   output logic [2*N_PTS*DATA_W-1:0] core_samples,
   input  logic [2*N_PTS*DATA_W-1:0] core_results,
   input  logic                      core_done
);

   localparam int N_BYTES = 2 * N_PTS;
   localparam int IDX_W   = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;
   localparam int VEC_W   = N_BYTES * DATA_W;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_BYTES - 1);

   if (N_PTS < 1 || DATA_W < 1) begin : g_bad_size
      $error("fft_io_sequencer: N_PTS and DATA_W must be positive");
   end
   if (LOAD_SW == READ_SW) begin : g_bad_sw_same
      $error("fft_io_sequencer: load and read switches must differ");
   end
   if (LOAD_SW >= SW_W || READ_SW >= SW_W || LOAD_SW < 0 || READ_SW < 0) begin : g_bad_sw_idx
      $error("fft_io_sequencer: switch index outside switch bank");
   end

   logic ld_rise;
   logic rd_rise;
   logic unused_sw;

   assign unused_sw = ^mode_sw;

   fio_edge_sync #(.STAGES(SYNC_STAGES)) u_ld_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .level (mode_sw[LOAD_SW]),
      .rise  (ld_rise)
   );

   fio_edge_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .level (mode_sw[READ_SW]),
      .rise  (rd_rise)
   );

   fio_state_e       st_q;
   logic [IDX_W-1:0] wr_idx_q;
   logic [IDX_W-1:0] rd_idx_q;
   logic             accepting;
   logic             take_res;
   logic             showing;

   assign accepting = (st_q == ST_IDLE) || (st_q == ST_LOAD);
   assign take_res  = (st_q == ST_WAIT) && core_done;
   assign showing   = (st_q == ST_SHOW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         wr_idx_q <= '0;
         rd_idx_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE, ST_LOAD: begin
               if (ld_rise) begin
                  if (wr_idx_q == LAST_IDX) begin
                     st_q     <= ST_KICK;
                     wr_idx_q <= '0;
                  end else begin
                     st_q     <= ST_LOAD;
                     wr_idx_q <= wr_idx_q + 1'b1;
                  end
               end
            end
            ST_KICK: begin
               st_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (core_done) begin
                  st_q     <= ST_SHOW;
                  rd_idx_q <= '0;
               end
            end
            ST_SHOW: begin
               if (rd_rise) begin
                  if (rd_idx_q == LAST_IDX) begin
                     st_q     <= ST_IDLE;
                     rd_idx_q <= '0;
                  end else begin
                     rd_idx_q <= rd_idx_q + 1'b1;
                  end
               end
            end
            default: begin
               st_q <= ST_IDLE;
            end
         endcase
      end
   end

   fio_byte_bank #(.DATA_W(DATA_W), .N_BYTES(N_BYTES)) u_load_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ld_rise && accepting),
      .wr_idx   (wr_idx_q),
      .wr_byte  (bus_in),
      .bulk_en  (1'b0),
      .bulk_vec ({VEC_W{1'b0}}),
      .vec      (core_samples)
   );

   logic [VEC_W-1:0] res_vec;

   fio_byte_bank #(.DATA_W(DATA_W), .N_BYTES(N_BYTES)) u_res_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (1'b0),
      .wr_idx   ({IDX_W{1'b0}}),
      .wr_byte  ({DATA_W{1'b0}}),
      .bulk_en  (take_res),
      .bulk_vec (core_results),
      .vec      (res_vec)
   );

   fio_phase_e phase;

   always_comb begin
      unique case (st_q)
         ST_IDLE:          phase = PH_IDLE;
         ST_LOAD:          phase = PH_LOAD;
         ST_KICK, ST_WAIT: phase = PH_PROC;
         ST_SHOW:          phase = PH_SHOW;
         default:          phase = PH_IDLE;
      endcase
   end

   fio_glyph_drv #(.ACTIVE_LOW(SEG_ACTIVE_LOW)) u_glyph (
      .phase (phase),
      .seg   (seg)
   );

   assign core_start = (st_q == ST_KICK);
   assign bus_oe     = {DATA_W{showing}};
   assign bus_out    = showing ? res_vec[rd_idx_q*DATA_W +: DATA_W] : '0;

endmodule

// File: rtl/fio_checker.sv
module fio_checker
   import fio_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter bit SEG_ACTIVE_LOW = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] bus_out,
   input logic [DATA_W-1:0] bus_oe,
   input logic [6:0]        seg,
   input logic              core_start,
   input logic              core_done
);

   localparam logic [6:0] G_IDLE = SEG_ACTIVE_LOW ? ~GLY_IDLE : GLY_IDLE;
   localparam logic [6:0] G_LOAD = SEG_ACTIVE_LOW ? ~GLY_LOAD : GLY_LOAD;
   localparam logic [6:0] G_PROC = SEG_ACTIVE_LOW ? ~GLY_PROC : GLY_PROC;
   localparam logic [6:0] G_SHOW = SEG_ACTIVE_LOW ? ~GLY_SHOW : GLY_SHOW;

   AST_RESET_QUIET: assert property (@(posedge clk)
      $rose(rst_n) |-> (bus_oe == '0) && (seg == G_IDLE) && !core_start); // R1

   AST_OE_ALL_OR_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe == '0) || (bus_oe == '1)); // R6

   AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe == '0) |-> (bus_out == '0)); // R6

   AST_OE_WITH_GLYPH: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe == '1) == (seg == G_SHOW)); // R9

   AST_GLYPH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (seg == G_IDLE) || (seg == G_LOAD) || (seg == G_PROC) || (seg == G_SHOW)); // R9

   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |=> !core_start); // R4

   AST_START_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |-> (seg == G_PROC) && ($past(seg) == G_LOAD)); // R4

   AST_SHOW_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_oe[0]) |-> $past(core_done) && ($past(seg) == G_PROC)); // R5

endmodule

bind fft_io_sequencer fio_checker #(
   .DATA_W         (DATA_W),
   .SEG_ACTIVE_LOW (SEG_ACTIVE_LOW)
) u_fio_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_out    (bus_out),
   .bus_oe     (bus_oe),
   .seg        (seg),
   .core_start (core_start),
   .core_done  (core_done)
);

// File: tb/fft_io_sequencer_bench.sv
module fft_io_sequencer_bench;

   localparam int CORE_LAT = 60;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  mode_sw = '0;
   logic [7:0]  bus_in = '0;
   logic [7:0]  bus_out;
   logic [7:0]  bus_oe;
   logic [6:0]  seg;
   logic        core_start;
   logic [63:0] core_samples;
   logic [63:0] core_results = '0;
   logic        core_done = 1'b0;

   always #5 clk = ~clk;

   fft_io_sequencer u_fft_io_sequencer (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_sw      (mode_sw),
      .bus_in       (bus_in),
      .bus_out      (bus_out),
      .bus_oe       (bus_oe),
      .seg          (seg),
      .core_start   (core_start),
      .core_samples (core_samples),
      .core_results (core_results),
      .core_done    (core_done)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int n_start = 0;
   logic [63:0] cap_samples = '0;
   int lat_cnt = 0;
   logic busy_m = 1'b0;

   function automatic logic [63:0] dft4(input logic [63:0] v);
      logic [7:0] r0, r1, r2, r3, i0, i1, i2, i3;
      logic [7:0] ar, ai, br, bi;
      logic [63:0] o;
      r0 = v[7:0];   i0 = v[15:8];
      r1 = v[23:16]; i1 = v[31:24];
      r2 = v[39:32]; i2 = v[47:40];
      r3 = v[55:48]; i3 = v[63:56];
      ar = r0 - r2; ai = i0 - i2;
      br = r1 - r3; bi = i1 - i3;
      o[7:0]   = r0 + r1 + r2 + r3;
      o[15:8]  = i0 + i1 + i2 + i3;
      o[23:16] = ar + bi;
      o[31:24] = ai - br;
      o[39:32] = r0 - r1 + r2 - r3;
      o[47:40] = i0 - i1 + i2 - i3;
      o[55:48] = ar - bi;
      o[63:56] = ai + br;
      return o;
   endfunction

   // behavioural FFT core: fixed latency, results valid only with done
   always @(posedge clk) begin
      core_done    <= 1'b0;
      core_results <= 64'hA5A5_5A5A_0F0F_F0F0;
      if (core_start) begin
         n_start     <= n_start + 1;
         cap_samples <= core_samples;
         busy_m      <= 1'b1;
         lat_cnt     <= 0;
      end else if (busy_m) begin
         if (lat_cnt == CORE_LAT) begin
            core_done    <= 1'b1;
            core_results <= dft4(cap_samples);
            busy_m       <= 1'b0;
         end else begin
            lat_cnt <= lat_cnt + 1;
         end
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic pulse(input int bitn, input logic [7:0] d, input int hold);
      @(negedge clk);
      bus_in = d;
      mode_sw[bitn] = 1'b1;
      repeat (hold) @(negedge clk);
      mode_sw[bitn] = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic frame(input logic [63:0] v, input int hold, input bit disturb);
      int s0;
      logic [63:0] ex;
      s0 = n_start;
      if (disturb) begin
         pulse(1, 8'h11, 6);
         chk("R10 read edge in idle keeps idle glyph", seg, 7'h3F);
         chk("R10 read edge in idle keeps pins input", bus_oe, 8'h00);
         mode_sw[7:2] = 6'h3F;
         repeat (8) @(negedge clk);
         chk("R11 other switch bits in idle", seg, 7'h3F);
         mode_sw[7:2] = 6'h00;
         repeat (4) @(negedge clk);
      end
      for (int j = 0; j < 8; j++) begin
         pulse(0, v[8*j +: 8], hold);
         if (disturb && j == 3) begin
            pulse(1, 8'h77, 6);
         end
         if (j < 7) begin
            chk("R2 R9 load glyph while loading", seg, 7'h38);
            chk("R4 no start before eighth byte", n_start, s0);
            chk("R6 pins input while loading", bus_oe, 8'h00);
         end
      end
      chk("R9 processing glyph", seg, 7'h73);
      chk("R6 pins input while processing", bus_oe, 8'h00);
      chk("R4 exactly one start per frame", n_start, s0 + 1);
      chk("R3 sample packing to core", cap_samples, v);
      if (disturb) begin
         pulse(0, 8'hEE, 6);
         pulse(1, 8'hEE, 6);
         chk("R5 strobes ignored while processing", seg, 7'h73);
      end
      repeat (80) @(negedge clk);
      chk("R9 output glyph", seg, 7'h5C);
      chk("R6 pins output in output phase", bus_oe, 8'hFF);
      chk("R5 no extra start", n_start, s0 + 1);
      ex = dft4(v);
      for (int j = 0; j < 8; j++) begin
         chk("R5 R7 result byte on bus", bus_out, ex[8*j +: 8]);
         if (disturb && j == 2) begin
            pulse(0, 8'h5A, 6);
            chk("R10 load edge in output phase ignored", bus_out, ex[8*j +: 8]);
            mode_sw[7:2] = 6'h3F;
            repeat (8) @(negedge clk);
            chk("R11 other switch bits in output phase", bus_out, ex[8*j +: 8]);
            mode_sw[7:2] = 6'h00;
            repeat (4) @(negedge clk);
         end
         pulse(1, 8'h00, hold);
      end
      chk("R8 idle glyph after last read", seg, 7'h3F);
      chk("R8 pins input after last read", bus_oe, 8'h00);
      chk("R8 bus quiet after last read", bus_out, 8'h00);
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [63:0] pat;
      repeat (4) @(negedge clk);
      chk("R1 idle glyph in reset", seg, 7'h3F);
      chk("R1 pins input in reset", bus_oe, 8'h00);
      chk("R1 bus zero in reset", bus_out, 8'h00);
      chk("R1 no start in reset", core_start, 1'b0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 idle glyph after reset", seg, 7'h3F);
      chk("R1 pins input after reset", bus_oe, 8'h00);

      frame(64'h0706_0504_0302_0100, 6, 1'b0);
      frame(64'hFFFF_FFFF_FFFF_FFFF, 25, 1'b0);
      frame(64'h8001_7F80_0180_FF7F, 6, 1'b1);
      for (int s = 0; s < 12; s++) begin
         for (int j = 0; j < 8; j++) begin
            pat[8*j +: 8] = 8'((s * 37) + (j * 53) + (s ^ j));
         end
         frame(pat, (s % 3 == 0) ? 14 : 6, (s % 4) == 1);
      end
      summary();
      $finish;
   end

endmodule